// File: doc/BRIEF.md
# Single-Instruction Repeat Controller

This block sits between instruction fetch and instruction decode and carries out a repeat command. When the decoder reports a repeat command with a count, the controller waits for the next fetched instruction word. It hands that word to decode and keeps a copy of it in a backup latch. It then stalls fetch and hands the latched copy to decode once per cycle until the requested number of executions has been issued. The instruction is read from program memory only once, so the program bus is free while the repeat runs.

A repeat in progress cannot be broken into. While the controller is busy, it grants no interrupt request. A request that arrives during the repeat is kept pending and is granted in the first cycle after busy drops. A count of zero executes the instruction once. Outside a repeat, fetched words pass straight through to decode and interrupt requests pass straight through to the grant.

Top module: `rep_unit`

## Requirements
- R1: After reset, busy, fetch_stall and irq_grant are 0 (with irq_req at 0).
- R2: While busy is 0, dec_word equals fetch_word and dec_valid equals fetch_valid in the same cycle.
- R3: A rep_valid pulse while idle sets busy from the next cycle. While the controller waits for the instruction to repeat, dec_valid follows fetch_valid, so it is 0 in every cycle without a fetched word.
- R4: The instruction to repeat is the first word fetched after the command. It is issued (dec_valid=1 with that word) exactly N times in total, where N is the count, or 1 when the count is 0. The first issue comes from fetch_word and the rest come from the backup latch.
- R5: fetch_stall is 1 in exactly N-1 cycles, which are the cycles right after the first issue. Each of those cycles issues the latched word, and fetch_word and fetch_valid have no effect on dec_word during them.
- R6: A count of 0 or 1 gives a single issue with no stall cycle.
- R7: busy falls in the cycle after the last issue. From that cycle on, fetch_stall is 0 and the pass-through of R2 applies.
- R8: irq_grant is 0 in every cycle in which busy is 1. An irq_req seen while busy is held pending and is granted (irq_grant=1) in the first cycle with busy at 0, after which the pending request is cleared.
- R9: rep_valid received while busy is ignored: the issue count and stall count of the repeat in progress are unchanged.
- R10: While busy is 0 and nothing is pending, irq_grant equals irq_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rep_valid | input | 1 | Decoded repeat command present |
| rep_count | input | CW (16) | Number of executions requested with the command |
| fetch_word | input | IW (24) | Instruction word from fetch |
| fetch_valid | input | 1 | fetch_word holds a valid instruction |
| irq_req | input | 1 | Interrupt request |
| dec_word | output | IW (24) | Instruction word handed to decode |
| dec_valid | output | 1 | dec_word is to be executed this cycle |
| fetch_stall | output | 1 | Fetch must hold its current word |
| busy | output | 1 | Repeat command in progress |
| irq_grant | output | 1 | Interrupt released to the core |

## Verification
Two situations are hard to reach from the ports. The first is an interrupt request that lands inside a long replay and has already been withdrawn when busy falls, so that only the held pending state can produce the grant. The second is a second repeat command that arrives in the middle of a replay. The stimulus pulses irq_req and rep_valid for single cycles at random points within the waiting and replay windows of each repeat. While fetch is stalled, it also drives fetch_word with the inverse of the repeated word, so that a leak from the fetch path shows up at once.

// File: rtl/rep_pkg.sv
package rep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_REPLAY = 2'd2
  } rep_state_e;
endpackage

// File: rtl/rep_counter.sv
module rep_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          is_one
);
  logic [CW-1:0] cnt_q;

  // A request of zero executions is run once.
  function automatic logic [CW-1:0] effective_count(input logic [CW-1:0] req);
    return (req == '0) ? {{(CW-1){1'b0}}, 1'b1} : req;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= effective_count(load_val);
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign is_one = (cnt_q == {{(CW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/rep_backup_latch.sv
module rep_backup_latch #(
  parameter int unsigned IW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [IW-1:0] d,
  output logic [IW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/rep_fsm.sv
module rep_fsm
  import rep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rep_valid,
  input  logic       fetch_valid,
  input  logic       cnt_is_one,
  output rep_state_e state,
  output logic       cnt_load,
  output logic       cnt_dec,
  output logic       latch_cap,
  output logic       last_issue
);
  rep_state_e state_d;

  always_comb begin
    state_d    = state;
    cnt_load   = 1'b0;
    cnt_dec    = 1'b0;
    latch_cap  = 1'b0;
    last_issue = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rep_valid) begin
          cnt_load = 1'b1;
          state_d  = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (fetch_valid) begin
          if (cnt_is_one) begin
            last_issue = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            latch_cap = 1'b1;
            cnt_dec   = 1'b1;
            state_d   = ST_REPLAY;
          end
        end
      end
      ST_REPLAY: begin
        if (cnt_is_one) begin
          last_issue = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/rep_irq_hold.sv
module rep_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic busy,
  output logic pending,
  output logic irq_grant
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pending <= 1'b0;
    else if (busy && irq_req) pending <= 1'b1;
    else if (!busy)           pending <= 1'b0;
  end

  assign irq_grant = !busy && (irq_req || pending);
endmodule

// File: rtl/rep_unit.sv
module rep_unit
  import rep_pkg::*;
#(
  parameter int unsigned IW = 24,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rep_valid,
  input  logic [CW-1:0] rep_count,
  input  logic [IW-1:0] fetch_word,
  input  logic          fetch_valid,
  input  logic          irq_req,
  output logic [IW-1:0] dec_word,
  output logic          dec_valid,
  output logic          fetch_stall,
  output logic          busy,
  output logic          irq_grant
);
  rep_state_e    state;
  logic          ev_load;
  logic          ev_dec;
  logic          ev_capture;
  logic          ev_last_issue;
  logic          cnt_is_one;
  logic          irq_pending;
  logic [IW-1:0] backup_word;

  rep_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rep_valid  (rep_valid),
    .fetch_valid(fetch_valid),
    .cnt_is_one (cnt_is_one),
    .state      (state),
    .cnt_load   (ev_load),
    .cnt_dec    (ev_dec),
    .latch_cap  (ev_capture),
    .last_issue (ev_last_issue)
  );

  rep_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_load),
    .load_val(rep_count),
    .dec     (ev_dec),
    .is_one  (cnt_is_one)
  );

  rep_backup_latch #(.IW(IW)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .cap  (ev_capture),
    .d    (fetch_word),
    .q    (backup_word)
  );

  assign busy        = (state != ST_IDLE);
  assign fetch_stall = (state == ST_REPLAY);
  assign dec_valid   = fetch_stall || fetch_valid;
  assign dec_word    = fetch_stall ? backup_word : fetch_word;

  rep_irq_hold u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .busy     (busy),
    .pending  (irq_pending),
    .irq_grant(irq_grant)
  );
endmodule

// File: rtl/rep_unit_chk.sv
module rep_unit_chk #(
  parameter int unsigned IW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rep_valid,
  input logic          irq_req,
  input logic [IW-1:0] dec_word,
  input logic          dec_valid,
  input logic          fetch_stall,
  input logic          busy,
  input logic          irq_grant,
  input logic          ev_capture,
  input logic          ev_last_issue
);
  // R5
  stall_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> busy && dec_valid);

  // R5
  replay_word_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && $past(fetch_stall)) |-> $stable(dec_word));

  // R5
  capture_starts_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> fetch_stall);

  // R7
  last_issue_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_issue |=> !busy && !fetch_stall);

  // R8
  no_grant_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_grant);

  // R8
  held_irq_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && irq_req) |=> (busy || irq_grant));

  // R9
  busy_ignores_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rep_valid && !ev_last_issue) |=> busy);
endmodule

bind rep_unit rep_unit_chk #(.IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rep_valid    (rep_valid),
  .irq_req      (irq_req),
  .dec_word     (dec_word),
  .dec_valid    (dec_valid),
  .fetch_stall  (fetch_stall),
  .busy         (busy),
  .irq_grant    (irq_grant),
  .ev_capture   (ev_capture),
  .ev_last_issue(ev_last_issue)
);

// File: tb/rep_unit_test.sv
`timescale 1ns/1ps
module rep_unit_test;
  localparam int IW = 24;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rep_valid = 1'b0;
  logic [CW-1:0] rep_count = '0;
  logic [IW-1:0] fetch_word = '0;
  logic          fetch_valid = 1'b0;
  logic          irq_req = 1'b0;
  logic [IW-1:0] dec_word;
  logic          dec_valid;
  logic          fetch_stall;
  logic          busy;
  logic          irq_grant;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rep_unit #(.IW(IW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .rep_valid(rep_valid), .rep_count(rep_count),
    .fetch_word(fetch_word), .fetch_valid(fetch_valid), .irq_req(irq_req),
    .dec_word(dec_word), .dec_valid(dec_valid), .fetch_stall(fetch_stall),
    .busy(busy), .irq_grant(irq_grant)
  );

  function automatic int exp_issues(input int cnt);
    return (cnt < 1) ? 1 : cnt;
  endfunction

  function automatic int exp_stalls(input int cnt);
    return exp_issues(cnt) - 1;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // gap: idle cycles before the word is fetched; irq_at/cmd_at: busy-cycle index for a pulse (-1 none)
  task automatic run_rep(input int cnt, input logic [IW-1:0] w, input int gap,
                         input int irq_at, input int cmd_at);
    int issues = 0;
    int stalls = 0;
    int k = 0;
    bit irq_seen = 1'b0;
    bit first_done = 1'b0;
    rep_valid = 1'b1; rep_count = cnt[CW-1:0]; fetch_valid = 1'b0;
    #1;
    check(busy == 1'b0, "R3 idle before command", busy, 0);
    tick();
    rep_valid = 1'b0;
    check(busy == 1'b1, "R3 busy after command", busy, 1);
    while (busy && k < 2000) begin
      irq_req   = (k == irq_at);
      rep_valid = (k == cmd_at);
      rep_count = 16'd7;
      if (fetch_stall) begin
        fetch_valid = 1'b1; fetch_word = ~w;
      end else if (!first_done && k >= gap) begin
        fetch_valid = 1'b1; fetch_word = w;
      end else begin
        fetch_valid = 1'b0; fetch_word = ~w;
      end
      #1;
      if (irq_req) irq_seen = 1'b1;
      check(irq_grant == 1'b0, "R8 no grant while busy", irq_grant, 0);
      if (!first_done && !fetch_valid)
        check(dec_valid == 1'b0, "R3 no issue while waiting", dec_valid, 0);
      if (fetch_stall) begin
        stalls++;
        check(dec_valid && dec_word == w, "R5 replayed word", dec_word, w);
      end
      if (dec_valid && dec_word == w) begin
        issues++;
        first_done = 1'b1;
      end
      tick();
      k++;
    end
    irq_req = 1'b0; rep_valid = 1'b0; fetch_valid = 1'b1; fetch_word = w ^ 24'h00ff00;
    #1;
    check(busy == 1'b0, "R7 busy dropped", busy, 0);
    check(fetch_stall == 1'b0, "R7 stall released", fetch_stall, 0);
    check(dec_word == (w ^ 24'h00ff00), "R7 pass-through resumes", dec_word, w ^ 24'h00ff00);
    if (cmd_at >= 0) begin
      check(issues == exp_issues(cnt), "R9 issues with ignored command", issues, exp_issues(cnt));
      check(stalls == exp_stalls(cnt), "R9 stalls with ignored command", stalls, exp_stalls(cnt));
    end else begin
      check(issues == exp_issues(cnt), "R4 issue count", issues, exp_issues(cnt));
      check(stalls == exp_stalls(cnt), "R5 stall count", stalls, exp_stalls(cnt));
    end
    if (cnt <= 1)
      check(stalls == 0, "R6 no stall for small count", stalls, 0);
    check(irq_grant == irq_seen, "R8 pending released", irq_grant, irq_seen);
    tick();
    fetch_valid = 1'b0;
    #1;
    check(irq_grant == 1'b0, "R8 pending cleared", irq_grant, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_0042);
    #1;
    check(busy == 0 && fetch_stall == 0 && irq_grant == 0, "R1 reset state",
          {busy, fetch_stall, irq_grant}, 0);
    #10 rst_n = 1'b1;
    tick();
    check(busy == 0 && fetch_stall == 0, "R1 after reset", {busy, fetch_stall}, 0);

    for (int i = 0; i < 4; i++) begin
      fetch_word = 24'(i * 24'h111111 + 24'h0a0b0c); fetch_valid = i[0];
      #1;
      check(dec_word == fetch_word && dec_valid == fetch_valid, "R2 pass-through",
            {dec_valid, dec_word}, {fetch_valid, fetch_word});
      tick();
    end

    irq_req = 1'b1; #1;
    check(irq_grant == 1'b1, "R10 grant follows request", irq_grant, 1);
    irq_req = 1'b0; #1;
    check(irq_grant == 1'b0, "R10 grant low", irq_grant, 0);
    tick();

    run_rep(0, 24'hc0ffee, 0, -1, -1);
    run_rep(1, 24'h123456, 2, 0, -1);
    run_rep(2, 24'habcdef, 0, 1, -1);
    run_rep(300, 24'h5a5a5a, 3, 150, -1);
    run_rep(9, 24'h0f0f0f, 1, 5, 4);

    for (int i = 0; i < 25; i++) begin
      int c, g, ia, ca;
      c  = int'($urandom_range(0, 40));
      g  = int'($urandom_range(0, 3));
      ia = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, g + exp_issues(c) - 1)) : -1;
      ca = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, g + exp_issues(c) - 1)) : -1;
      run_rep(c, 24'($urandom()), g, ia, ca);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule